// File: doc/BRIEF.md
# DDR2 Mode Register Command Tracker

This block sits beside a DDR2 command bus and listens for mode register writes. From each accepted write it keeps the decoded operating settings: CAS latency, posted additive latency, burst length and burst ordering. From these it presents the read latency and the write latency that the rest of a memory controller uses to time its data phases. A field that holds an unsupported code is rejected on its own, so the last good value of that field stays in force. An error flag reports the rejection.

Two bits of the mode word get special handling. When the reserved test bit is set, the write programs nothing and only reports that test mode was requested. The DLL reset request bit is never stored: it gives a one-cycle pulse. That pulse starts a settling window of 200 clock cycles. A READ command issued inside the window is flagged as a timing violation. A ready output shows when the window has ended, and every new DLL reset starts the window again.

The tracker only observes the bus. It drives no command, and every one of its outputs comes from a register that is updated on the clock edge that samples the command.

Top module: `ddr2_mode_tracker`

## Requirements
- R1: After reset the outputs read CAS latency 3, additive latency 0, burst length 4 (bl8_o=0), sequential order (burst_il_o=0), read latency 3 and write latency 2. At the same time test_mode_o, cfg_err_o, dll_reset_o and read_viol_o are 0, and dll_ready_o is 1.
- R2: A mode register write is accepted only when cmd_valid=1, cmd_code=3'b000 and cmd_bank=2'b00. Writes to other banks, or with cmd_valid=0, change no output. Accepted settings appear in the cycle after the sampling edge.
- R3: The burst length code in cmd_addr[2:0] is 3'b010 for length 4 and 3'b011 for length 8 (bl8_o=1). Any other code leaves the burst length unchanged.
- R4: cmd_addr[3] selects the burst order: 0 for sequential and 1 for interleaved, shown on burst_il_o.
- R5: The CAS latency code in cmd_addr[6:4] is accepted only for the values 3, 4 and 5. Any other code leaves cl_o unchanged, so cl_o is always 3, 4 or 5.
- R6: The additive latency in cmd_addr[11:9] is accepted for the values 0 to 4. Larger values leave al_o unchanged.
- R7: rl_o equals cl_o plus al_o, and wl_o equals rl_o minus 1.
- R8: cfg_err_o becomes 1 after a normal write in which any of the burst length, CAS latency or additive latency codes is unsupported. It becomes 0 after a normal write in which all three codes are supported. A test-mode write leaves it unchanged.
- R9: When cmd_addr[7]=1 the write updates no setting and gives no DLL reset. test_mode_o becomes 1 and stays 1 until the next normal write (cmd_addr[7]=0).
- R10: A normal write with cmd_addr[8]=1 makes dll_reset_o 1 for exactly the next cycle. The bit is not retained.
- R11: dll_ready_o is 0 from the DLL reset edge until 199 edges after it. A READ (cmd_valid=1, cmd_code=3'b101) sampled fewer than 200 cycles after the DLL reset edge sets read_viol_o to 1 for the next cycle. A READ sampled 200 or more cycles after that edge is not flagged.
- R12: A new DLL reset during the window restarts the 200-cycle count from its own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command on the bus is valid this cycle |
| cmd_code | input | 3 | Command code (3'b000 mode write, 3'b101 READ) |
| cmd_bank | input | 2 | Bank bits of the command |
| cmd_addr | input | 13 | Address bits carrying the mode word |
| cl_o | output | 3 | Current CAS latency |
| al_o | output | 3 | Current additive latency |
| bl8_o | output | 1 | 1 for burst length 8, 0 for 4 |
| burst_il_o | output | 1 | 1 for interleaved order, 0 for sequential |
| rl_o | output | 4 | Read latency in clocks |
| wl_o | output | 4 | Write latency in clocks |
| test_mode_o | output | 1 | Last mode write requested test mode |
| cfg_err_o | output | 1 | Last normal write held an unsupported code |
| dll_reset_o | output | 1 | One-cycle DLL reset pulse |
| dll_ready_o | output | 1 | Settling window has ended |
| read_viol_o | output | 1 | A READ was issued inside the settling window |

## Verification
Every result is due one clock after the edge that samples its command. That covers the settings, both latencies and both flags, the DLL pulse, the ready level and the violation pulse. The driver applies a command on a falling edge and pushes the expected output set into a queue. The monitor pops that set 2 ns after the next rising edge and compares it, so each comparison lands on the cycle in which the result first becomes visible. Idle cycles push expectations too, so the ready level is checked on every cycle of the settling window. The READ probes sit at offsets of 100, 199 and 200 cycles, and at 150 cycles after a restart, to cover both sides of the window edge.

// File: rtl/ddr2_mrt_pkg.sv
package ddr2_mrt_pkg;

    localparam int FLD_W = 3;

    typedef enum logic [2:0] {
        CMD_MRS  = 3'b000,
        CMD_REF  = 3'b001,
        CMD_PRE  = 3'b010,
        CMD_ACT  = 3'b011,
        CMD_WR   = 3'b100,
        CMD_RD   = 3'b101,
        CMD_NOP  = 3'b111
    } cmd_e;

    // Field positions inside the mode word
    localparam int BL_LSB  = 0;
    localparam int BT_BIT  = 3;
    localparam int CL_LSB  = 4;
    localparam int TM_BIT  = 7;
    localparam int DLL_BIT = 8;
    localparam int AL_LSB  = 9;

    localparam logic [FLD_W-1:0] BL_CODE4 = 3'b010;
    localparam logic [FLD_W-1:0] BL_CODE8 = 3'b011;
    localparam logic [FLD_W-1:0] CL_MIN   = 3'd3;
    localparam logic [FLD_W-1:0] CL_MAX   = 3'd5;
    localparam logic [FLD_W-1:0] AL_MAX   = 3'd4;

    typedef struct packed {
        logic [FLD_W-1:0] cl;
        logic [FLD_W-1:0] al;
        logic             bl8;
        logic             interleave;
    } mode_cfg_t;

    typedef struct packed {
        mode_cfg_t cand;
        logic      cl_ok;
        logic      al_ok;
        logic      bl_ok;
        logic      test;
        logic      dll;
    } mr_fields_t;

    localparam mode_cfg_t RESET_CFG = '{cl: 3'd3, al: 3'd0, bl8: 1'b0, interleave: 1'b0};

    function automatic logic cl_supported(input logic [FLD_W-1:0] code);
        return (code >= CL_MIN) && (code <= CL_MAX);
    endfunction

    function automatic logic al_supported(input logic [FLD_W-1:0] code);
        return code <= AL_MAX;
    endfunction

    function automatic logic bl_supported(input logic [FLD_W-1:0] code);
        return (code == BL_CODE4) || (code == BL_CODE8);
    endfunction

endpackage

// File: rtl/ddr2_mrt_decode.sv
module ddr2_mrt_decode
    import ddr2_mrt_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output mr_fields_t        fields
);

    logic [FLD_W-1:0] bl_code;
    logic [FLD_W-1:0] cl_code;
    logic [FLD_W-1:0] al_code;
    logic             unused_hi;

    assign bl_code   = addr[BL_LSB +: FLD_W];
    assign cl_code   = addr[CL_LSB +: FLD_W];
    assign al_code   = addr[AL_LSB +: FLD_W];
    assign unused_hi = ^addr[ADDR_W-1:AL_LSB+FLD_W];

    always_comb begin
        fields                 = '0;
        fields.cand.cl         = cl_code;
        fields.cand.al         = al_code;
        fields.cand.bl8        = (bl_code == BL_CODE8);
        fields.cand.interleave = addr[BT_BIT];
        fields.cl_ok           = cl_supported(cl_code);
        fields.al_ok           = al_supported(al_code);
        fields.bl_ok           = bl_supported(bl_code);
        fields.test            = addr[TM_BIT];
        fields.dll             = addr[DLL_BIT];
    end

endmodule

// File: rtl/ddr2_mrt_store.sv
module ddr2_mrt_store
    import ddr2_mrt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  mr_fields_t fields,
    output mode_cfg_t  cfg,
    output logic       test_mode,
    output logic       cfg_err,
    output logic       dll_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= RESET_CFG;
            test_mode <= 1'b0;
            cfg_err   <= 1'b0;
            dll_pulse <= 1'b0;
        end else begin
            dll_pulse <= 1'b0;
            if (wr) begin
                if (fields.test) begin
                    test_mode <= 1'b1;
                end else begin
                    test_mode      <= 1'b0;
                    cfg.interleave <= fields.cand.interleave;
                    if (fields.cl_ok) cfg.cl  <= fields.cand.cl;
                    if (fields.al_ok) cfg.al  <= fields.cand.al;
                    if (fields.bl_ok) cfg.bl8 <= fields.cand.bl8;
                    cfg_err   <= !(fields.cl_ok && fields.al_ok && fields.bl_ok);
                    dll_pulse <= fields.dll;
                end
            end
        end
    end

endmodule

// File: rtl/ddr2_mrt_window.sv
module ddr2_mrt_window #(
    parameter int WIN = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rd,
    output logic ready,
    output logic viol
);

    localparam int CNT_W = $clog2(WIN);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WIN - 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            viol   <= 1'b0;
        end else begin
            viol <= rd && (remain != '0);
            if (start) begin
                remain <= LOAD;
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign ready = (remain == '0);

endmodule

// File: rtl/ddr2_mrt_latency.sv
module ddr2_mrt_latency
    import ddr2_mrt_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  mode_cfg_t        cfg,
    output logic [LAT_W-1:0] rl,
    output logic [LAT_W-1:0] wl
);

    always_comb begin
        rl = LAT_W'(cfg.cl) + LAT_W'(cfg.al);
        wl = rl - 1'b1;
    end

endmodule

// File: rtl/ddr2_mode_tracker.sv
module ddr2_mode_tracker
    import ddr2_mrt_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int LAT_W  = 4,
    parameter int WIN    = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic [FLD_W-1:0]  cl_o,
    output logic [FLD_W-1:0]  al_o,
    output logic              bl8_o,
    output logic              burst_il_o,
    output logic [LAT_W-1:0]  rl_o,
    output logic [LAT_W-1:0]  wl_o,
    output logic              test_mode_o,
    output logic              cfg_err_o,
    output logic              dll_reset_o,
    output logic              dll_ready_o,
    output logic              read_viol_o
);

    mr_fields_t fields;
    mode_cfg_t  cfg;
    logic       mrs_seen;
    logic       rd_seen;

    assign mrs_seen = cmd_valid && (cmd_code == CMD_MRS) && (cmd_bank == '0);
    assign rd_seen  = cmd_valid && (cmd_code == CMD_RD);

    ddr2_mrt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (cmd_addr),
        .fields (fields)
    );

    ddr2_mrt_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr        (mrs_seen),
        .fields    (fields),
        .cfg       (cfg),
        .test_mode (test_mode_o),
        .cfg_err   (cfg_err_o),
        .dll_pulse (dll_reset_o)
    );

    ddr2_mrt_window #(.WIN(WIN)) u_win (
        .clk   (clk),
        .rst   (rst),
        .start (mrs_seen && fields.dll && !fields.test),
        .rd    (rd_seen),
        .ready (dll_ready_o),
        .viol  (read_viol_o)
    );

    ddr2_mrt_latency #(.LAT_W(LAT_W)) u_lat (
        .cfg (cfg),
        .rl  (rl_o),
        .wl  (wl_o)
    );

    assign cl_o       = cfg.cl;
    assign al_o       = cfg.al;
    assign bl8_o      = cfg.bl8;
    assign burst_il_o = cfg.interleave;

endmodule

// File: rtl/ddr2_mrt_chk.sv
module ddr2_mrt_chk #(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int LAT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [2:0]        cl_o,
    input logic [2:0]        al_o,
    input logic              bl8_o,
    input logic              burst_il_o,
    input logic [LAT_W-1:0]  rl_o,
    input logic [LAT_W-1:0]  wl_o,
    input logic              dll_reset_o,
    input logic              dll_ready_o,
    input logic              read_viol_o
);

    logic rd_cmd;
    logic mrs_cmd;
    logic other_bank;

    assign rd_cmd     = cmd_valid && (cmd_code == 3'b101);
    assign mrs_cmd    = cmd_valid && (cmd_code == 3'b000) && (cmd_bank == '0);
    assign other_bank = cmd_valid && (cmd_code == 3'b000) && (cmd_bank != '0);

    assert_early_read_flagged_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && !dll_ready_o) |=> read_viol_o);

    assert_late_read_clean_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && dll_ready_o) |=> !read_viol_o);

    assert_pulse_opens_window_R10: assert property (@(posedge clk) disable iff (rst)
        dll_reset_o |-> !dll_ready_o);

    assert_test_write_inert_R9: assert property (@(posedge clk) disable iff (rst)
        (mrs_cmd && cmd_addr[7]) |=> ($stable(cl_o) && $stable(al_o) && $stable(bl8_o)
                                      && $stable(burst_il_o) && !dll_reset_o));

    assert_other_bank_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        other_bank |=> ($stable(cl_o) && $stable(al_o) && $stable(bl8_o) && $stable(burst_il_o)));

    assert_cl_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (cl_o >= 3'd3) && (cl_o <= 3'd5));

    assert_wl_below_rl_R7: assert property (@(posedge clk) disable iff (rst)
        (wl_o + 1'b1) == rl_o);

endmodule

bind ddr2_mode_tracker ddr2_mrt_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .LAT_W(LAT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_bank    (cmd_bank),
    .cmd_addr    (cmd_addr),
    .cl_o        (cl_o),
    .al_o        (al_o),
    .bl8_o       (bl8_o),
    .burst_il_o  (burst_il_o),
    .rl_o        (rl_o),
    .wl_o        (wl_o),
    .dll_reset_o (dll_reset_o),
    .dll_ready_o (dll_ready_o),
    .read_viol_o (read_viol_o)
);

// File: tb/ddr2_mode_tracker_tb_top.sv
module ddr2_mode_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'b111;
    logic [1:0]  cmd_bank = 2'b00;
    logic [12:0] cmd_addr = '0;
    logic [2:0]  cl_o, al_o;
    logic        bl8_o, burst_il_o;
    logic [3:0]  rl_o, wl_o;
    logic        test_mode_o, cfg_err_o, dll_reset_o, dll_ready_o, read_viol_o;

    always #4 clk = ~clk;

    ddr2_mode_tracker dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cl_o(cl_o), .al_o(al_o),
        .bl8_o(bl8_o), .burst_il_o(burst_il_o), .rl_o(rl_o), .wl_o(wl_o),
        .test_mode_o(test_mode_o), .cfg_err_o(cfg_err_o), .dll_reset_o(dll_reset_o),
        .dll_ready_o(dll_ready_o), .read_viol_o(read_viol_o)
    );

    typedef struct {
        string      req;
        logic [20:0] vec;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    // reference state built from the requirements
    logic [2:0] m_cl = 3'd3, m_al = 3'd0;
    logic       m_bl8 = 0, m_il = 0, m_tm = 0, m_err = 0;
    bit         have_rst = 0;
    int         rst_c = 0;
    int         cyc = 0;

    function automatic logic [12:0] mr(input int cl, input int bl, input int bt,
                                       input int al, input int tm, input int dll);
        logic [12:0] w;
        w = '0;
        w[2:0]  = 3'(bl);
        w[3]    = 1'(bt);
        w[6:4]  = 3'(cl);
        w[7]    = 1'(tm);
        w[8]    = 1'(dll);
        w[11:9] = 3'(al);
        return w;
    endfunction

    task automatic step(input logic v, input logic [2:0] code, input logic [1:0] bank,
                        input logic [12:0] addr, input string req);
        bit   is_mrs, is_rd, bad, m_dr, m_viol, m_rdy;
        logic [3:0] rl;
        exp_t e;
        @(negedge clk);
        cmd_valid = v; cmd_code = code; cmd_bank = bank; cmd_addr = addr;
        is_mrs = v && code == 3'b000 && bank == 2'b00;
        is_rd  = v && code == 3'b101;
        m_viol = is_rd && have_rst && (cyc - rst_c < 200);
        m_dr   = 0;
        if (is_mrs) begin
            if (addr[7]) m_tm = 1;
            else begin
                m_tm = 0; bad = 0;
                if (addr[6:4] >= 3 && addr[6:4] <= 5) m_cl = addr[6:4]; else bad = 1;
                if (addr[2:0] == 3'b010) m_bl8 = 0;
                else if (addr[2:0] == 3'b011) m_bl8 = 1;
                else bad = 1;
                if (addr[11:9] <= 4) m_al = addr[11:9]; else bad = 1;
                m_il  = addr[3];
                m_err = bad;
                if (addr[8]) begin m_dr = 1; have_rst = 1; rst_c = cyc; end
            end
        end
        m_rdy = !have_rst || (cyc - rst_c >= 199);
        rl = 4'(m_cl) + 4'(m_al);
        e.req = req;
        e.vec = {m_cl, m_al, m_bl8, m_il, rl, rl - 4'd1, m_tm, m_err, m_dr, m_rdy, m_viol};
        q.push_back(e);
        cyc++;
    endtask

    // monitor: results are due one edge after the command
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            logic [20:0] act;
            e = q.pop_front();
            act = {cl_o, al_o, bl8_o, burst_il_o, rl_o, wl_o, test_mode_o,
                   cfg_err_o, dll_reset_o, dll_ready_o, read_viol_o};
            n_checks++;
            if (act !== e.vec) begin
                n_errors++;
                $display("FAIL %s: actual=%h expected=%h", e.req, act, e.vec);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(0, 3'b111, 0, '0, "R1");
        step(1, 3'b000, 0, mr(4, 3, 0, 0, 0, 0), "R3");
        step(1, 3'b000, 0, mr(5, 2, 1, 2, 0, 0), "R7");
        step(1, 3'b000, 0, mr(3, 2, 0, 0, 0, 0), "R4");
        step(1, 3'b000, 0, mr(7, 3, 0, 1, 0, 0), "R5");
        step(1, 3'b000, 0, mr(3, 5, 0, 0, 0, 0), "R3");
        step(1, 3'b000, 0, mr(4, 2, 0, 6, 0, 0), "R6");
        step(1, 3'b000, 0, mr(5, 2, 1, 3, 0, 0), "R8");
        step(1, 3'b000, 0, mr(3, 3, 0, 0, 1, 1), "R9");
        step(1, 3'b000, 0, mr(6, 4, 0, 0, 1, 0), "R8");
        step(1, 3'b000, 1, mr(4, 3, 0, 0, 0, 1), "R2");
        step(0, 3'b000, 0, mr(4, 3, 0, 0, 0, 1), "R2");
        step(1, 3'b101, 0, '0, "R11");
        step(1, 3'b000, 0, mr(4, 3, 0, 1, 0, 1), "R10");
        step(0, 3'b111, 0, '0, "R10");
        while (cyc - rst_c < 100) step(0, 3'b111, 0, '0, "R11");
        step(1, 3'b101, 0, '0, "R11");
        step(1, 3'b000, 0, mr(5, 2, 0, 0, 0, 1), "R12");
        while (cyc - rst_c < 150) step(0, 3'b111, 0, '0, "R12");
        step(1, 3'b101, 0, '0, "R12");
        while (cyc - rst_c < 199) step(0, 3'b111, 0, '0, "R11");
        step(1, 3'b101, 0, '0, "R11");
        step(1, 3'b101, 0, '0, "R11");
        step(0, 3'b111, 0, '0, "R11");
        repeat (3) @(posedge clk);
        #3;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule